// File: doc/BRIEF.md
# Serial Input Expander Read Controller

This block is the host side of a three-wire link to a chain of 8-bit parallel-in/serial-out input registers. A single request on `start` makes it drive an active-low strobe that captures every parallel input in the chain at once. It then releases the strobe, which puts the registers in shift mode. It generates a divided shift clock, samples the returned serial data stream, and assembles 8×`NUM_DEV` bits into one parallel word.

The bits arrive most significant first. The device wired closest to the host delivers the first byte, and that byte lands in the top of the word. When the transfer completes, the word appears with a one-cycle valid strobe. The read side has no ready input and so applies no back-pressure. The consumer must take `rd_word` in the cycle `rd_valid` is high. The word then stays unchanged until the next transfer starts shifting.

Top module: `serin_reader`

## Requirements
- R1: After reset, and whenever idle, `sh_load_n` is high, `sh_clk` is low, and both `busy` and `rd_valid` are low.
- R2: A `start` accepted while idle drives `sh_load_n` low for exactly `LOAD_CYC` system cycles, starting the cycle after `start`. `sh_clk` stays low for the whole time the strobe is low.
- R3: After the strobe returns high, exactly 8×`NUM_DEV` rising edges appear on `sh_clk`. Afterwards `sh_clk` rests low and the strobe stays high.
- R4: Each high phase and each low phase of `sh_clk` between rising edges lasts `DIV_HALF` system cycles. `sh_clk` comes from a register and never toggles while idle.
- R5: `sh_din` passes through a two-flop synchroniser. It is sampled in the last cycle of each low phase, before every rising edge. The first sample becomes `rd_word[8*NUM_DEV-1]` and each later sample goes one position lower. The nearest device thus fills bits [8*NUM_DEV-1 : 8*NUM_DEV-8].
- R6: `busy` is high from the cycle after an accepted `start` through the cycle of `rd_valid`. `rd_valid` is high for exactly one cycle, with the finished word on `rd_word`.
- R7: `start` asserted while `busy` is high has no effect. No second strobe follows, and the running transfer finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one read of the chain |
| busy | output | 1 | Transfer in progress |
| sh_load_n | output | 1 | Active-low capture strobe; high selects shift mode |
| sh_clk | output | 1 | Shift clock to the chain |
| sh_din | input | 1 | Serial data returned by the chain |
| rd_valid | output | 1 | One-cycle strobe marking a finished word |
| rd_word | output | 8*NUM_DEV | Assembled word, nearest device in the top byte |

## Verification
The bench builds two chained devices with `DIV_HALF` = 2 and `LOAD_CYC` = 3. A divider of 2 is the smallest setting at which the synchroniser delay still fits inside one low phase, so every sample lands on the tightest margin. Two devices make a 16-bit word, which exposes device ordering and byte concatenation. Every value of the upper byte is swept against a derived lower byte, walking ones and zeros cover each position, and every fourth transfer carries a stray `start` mid-shift.

// File: rtl/serin_pkg.sv
package serin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } rd_state_t;

  localparam int BITS_PER_DEV = 8;

endpackage

// File: rtl/serin_sync.sv
module serin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d_async};
  end

  assign d_sync = pipe[STAGES-1];

endmodule

// File: rtl/serin_clkgen.sv
module serin_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int PW = $clog2(DIV_HALF + 1);

  logic [PW-1:0] ph;
  logic          hi;
  logic          ph_end;

  assign ph_end = (ph == PW'(DIV_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
      hi <= 1'b0;
    end else if (!run) begin
      ph <= '0;
      hi <= 1'b0;
    end else if (ph_end) begin
      ph <= '0;
      hi <= ~hi;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign sclk      = hi;
  assign rise_tick = run && !hi && ph_end;
  assign fall_tick = run &&  hi && ph_end;

  // R4: a low-phase end is followed by a rising shift clock
  p_rise_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> $rose(sclk));

  // R4: no shift clock activity outside the shift phase
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);

endmodule

// File: rtl/serin_shift.sv
module serin_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         din,
  output logic [W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (take) word <= {word[W-2:0], din};
  end

endmodule

// File: rtl/serin_reader.sv
module serin_reader
  import serin_pkg::*;
#(
  parameter int NUM_DEV  = 2,
  parameter int DIV_HALF = 2,
  parameter int LOAD_CYC = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  output logic                            busy,
  output logic                            sh_load_n,
  output logic                            sh_clk,
  input  logic                            sh_din,
  output logic                            rd_valid,
  output logic [BITS_PER_DEV*NUM_DEV-1:0] rd_word
);

  localparam int W   = BITS_PER_DEV * NUM_DEV;
  localparam int BCW = $clog2(W);
  localparam int LCW = $clog2(LOAD_CYC + 1);

  initial begin
    assert (DIV_HALF >= 2) else $error("DIV_HALF below 2 breaks sampling margin");
    assert (LOAD_CYC >= 1) else $error("LOAD_CYC must be at least 1");
  end

  rd_state_t      state;
  logic [LCW-1:0] lcnt;
  logic [BCW-1:0] bcnt;
  logic           run, rise_tick, fall_tick, din_s;

  assign run = (state == ST_SHIFT);

  serin_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sh_din), .d_sync(din_s)
  );

  serin_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(sh_clk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  serin_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .take(rise_tick), .din(din_s), .word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      lcnt  <= '0;
      bcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          lcnt  <= '0;
        end
        ST_LOAD: if (lcnt == LCW'(LOAD_CYC - 1)) begin
          state <= ST_SHIFT;
          bcnt  <= '0;
        end else begin
          lcnt <= lcnt + 1'b1;
        end
        ST_SHIFT: if (fall_tick) begin
          if (bcnt == BCW'(W - 1)) state <= ST_DONE;
          else                     bcnt  <= bcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign sh_load_n = (state != ST_LOAD);
  assign rd_valid  = (state == ST_DONE);

  // R2: shift clock quiet while the capture strobe is low
  p_sclk_quiet_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_load_n |-> !sh_clk);

  // R6: completion strobe lasts one cycle
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R6: busy only drops right after the completion strobe
  p_busy_ends_after_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rd_valid));

  // R7: once past the strobe, a transfer never re-captures
  p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sh_load_n) |=> sh_load_n);

  // R3: the shift clock only rises during the shift phase
  p_rise_only_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_clk) |-> $past(state == ST_SHIFT));

endmodule

// File: tb/sim_serin_reader.sv
module sim_serin_reader;
  localparam int NDEV = 2;
  localparam int DH   = 2;
  localparam int LC   = 3;
  localparam int W    = 8 * NDEV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  wire  busy, load_n, sclk, valid, din;
  wire  [W-1:0] word;

  always #2.5 clk = ~clk;

  serin_reader #(.NUM_DEV(NDEV), .DIV_HALF(DH), .LOAD_CYC(LC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .sh_load_n(load_n), .sh_clk(sclk), .sh_din(din),
    .rd_valid(valid), .rd_word(word)
  );

  // model of the external chain: capture on strobe, shift on rising clock
  logic [W-1:0] pat = '0;
  logic [W-1:0] chain = '0;
  always @(negedge load_n or posedge sclk) begin
    if (!load_n) chain <= pat;
    else         chain <= {chain[W-2:0], 1'b0};
  end
  assign din = chain[W-1];

  int checks = 0, fails = 0;
  int n_load = 0, n_bad_load = 0, n_rise = 0, n_bad_duty = 0, n_valid = 0;
  int run_len = 0;
  bit seen_fall = 0;
  logic sclk_q = 1'b0;
  logic [W-1:0] got = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!load_n) n_load++;
      if (!load_n && sclk) n_bad_load++;
      if (sclk && !sclk_q) begin
        n_rise++;
        if (seen_fall && run_len != DH) n_bad_duty++;
        run_len = 1;
      end else if (!sclk && sclk_q) begin
        if (run_len != DH) n_bad_duty++;
        run_len = 1;
        seen_fall = 1;
      end else begin
        run_len++;
      end
      if (valid) begin
        n_valid++;
        got = word;
        seen_fall = 0;
      end
      sclk_q = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [W-1:0] p, input bit stray);
    int s_load, s_bad, s_rise, s_duty, s_valid;
    @(negedge clk); #1;
    pat = p;
    s_load = n_load; s_bad = n_bad_load; s_rise = n_rise;
    s_duty = n_bad_duty; s_valid = n_valid;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    chk(busy === 1'b1, "R6 busy after start", W'(busy), W'(1));
    chk(load_n === 1'b0, "R2 strobe low after start", W'(load_n), W'(0));
    for (int k = 0; k < 400; k++) begin
      if (n_valid != s_valid) break;
      if (stray && k == 20) start = 1'b1;
      if (stray && k == 21) start = 1'b0;
      @(negedge clk); #1;
    end
    start = 1'b0;
    chk(n_valid - s_valid == 1, "R6 one valid", W'(n_valid - s_valid), W'(1));
    chk(got === p, "R5 word", got, p);
    chk(n_rise - s_rise == W, "R3 edge count", W'(n_rise - s_rise), W'(W));
    chk(n_load - s_load == LC, "R2 strobe length", W'(n_load - s_load), W'(LC));
    chk(n_bad_load == s_bad, "R2 clock in load", W'(n_bad_load - s_bad), W'(0));
    chk(n_bad_duty == s_duty, "R4 phase length", W'(n_bad_duty - s_duty), W'(0));
    @(negedge clk); #1;
    chk(busy === 1'b0 && valid === 1'b0, "R6 end of busy/valid",
        W'({busy, valid}), W'(0));
    chk(load_n === 1'b1 && sclk === 1'b0, "R3 rest state", W'({load_n, sclk}), W'(2));
    s_load = n_load; s_rise = n_rise;
    repeat (3) @(negedge clk);
    #1;
    chk(n_load == s_load && n_rise == s_rise, "R7 no queued transfer",
        W'(n_load - s_load), W'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({load_n, sclk, busy, valid} === 4'b1000, "R1 reset state",
        W'({load_n, sclk, busy, valid}), W'(4'b1000));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk({load_n, sclk, busy, valid} === 4'b1000, "R1 idle state",
        W'({load_n, sclk, busy, valid}), W'(4'b1000));
    for (int b = 0; b < 256; b++)
      txn({b[7:0], b[7:0] ^ 8'h5A}, (b % 4) == 3);
    for (int i = 0; i < W; i++) txn(W'(1) << i, 1'b0);
    for (int i = 0; i < W; i++) txn(~(W'(1) << i), 1'b0);
    txn('0, 1'b1);
    txn('1, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule